// File: doc/BRIEF.md
# Shared-Unit Four-Lane Processing Group

This block is one processing group of a configurable SIMD/VLIW array. It holds four functional units. Each unit has its own integer ALU. All four units share one pipelined multiplier and one memory request port. A statically configured operand crossbar feeds each unit's two operand inputs. Each input can come from any of eight group sources: the four external operand words, or the four registered unit results, which act as the local bypass. The crossbar has no route back into storage.

The group runs in one of two modes. In instruction-parallel mode each unit executes its own decoded micro-op. In data-parallel mode unit 0's micro-op stream drives every unit, and unit k sees that stream k cycles later. The multiply and memory operations of one instruction therefore reach the shared units in different cycles, so no arbitration or stall is needed. The configuration word holds the eight crossbar selects and the mode bit. It is loaded through a write strobe and takes effect only while the group is idle. If two units still claim a shared unit in the same cycle, the lowest-numbered unit is served and a sticky error flag records the event.

Top module: `pe_group`

## Requirements
- R1: Synchronous active-high reset clears every result valid bit, the memory request and the error flag. It also zeroes the configuration word, which gives instruction-parallel mode with every operand select at source 0.
- R2: The opcode encodings are 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 5 MUL, 6 LOAD and 7 STORE. Unit k's opcode sits at `uop_op[3k+2:3k]`. An ALU opcode (0 to 4) is computed modulo 2^DATA_W on operands A and B. The result appears in the unit's result register, with its valid bit set, one clock after issue.
- R3: For unit k, operand A's select is at configuration bits [6k+2:6k] and operand B's select is at [6k+5:6k+3]. Select values 0 to 3 pick external operand word 0 to 3 (`src_data[16j+15:16j]` at the default width). Select values 4 to 7 pick the result register of unit 0 to 3.
- R4: A MUL returns the low DATA_W bits of A times B in the issuing unit's result register, with valid set, two clocks after issue. A new MUL can issue every cycle.
- R5: LOAD and STORE raise `mem_req` one clock after issue. The request carries the address (low ADDR_W bits of A), the issuing unit's index, and `mem_we` = 1 for STORE. A STORE's write data is B. Memory operations set no result valid bit.
- R6: When two or more units claim the multiplier, or two or more claim the memory port, in the same cycle, only the lowest-numbered claimant is served. `contention_err` then rises one clock later and stays high until reset.
- R7: Configuration bit 24 selects data-parallel mode. A configuration write is accepted only in a cycle with no micro-op valid, no skewed op pending and no multiply in flight. Otherwise it is ignored.
- R8: In data-parallel mode the valid bits and opcodes of units 1 to 3 are ignored. Unit k executes unit 0's micro-op k cycles after it was presented, using its own crossbar selects. One MUL instruction therefore completes in units 0, 1, 2 and 3 on four consecutive clocks without raising the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 25 | Crossbar selects and mode bit |
| uop_valid | input | 4 | Per-unit micro-op valid |
| uop_op | input | 12 | Per-unit 3-bit opcodes |
| src_data | input | 4*DATA_W | External operand words |
| res_valid | output | 4 | Per-unit result valid |
| res_data | output | 4*DATA_W | Per-unit result registers |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Store data |
| mem_fu | output | 2 | Index of the requesting unit |
| contention_err | output | 1 | Sticky shared-unit contention flag |

## Verification
The hardest behaviour to reach from the ports is the data-parallel skew. The skew is visible only as the same product pattern spread across four result registers on four consecutive clocks. The bench can confirm it only after a configuration write has been accepted during an idle cycle. The stimulus first completes an idle configuration write with the mode bit set. It then presents a single MUL on unit 0, together with conflicting ADDs on units 1 to 3 that must be ignored, and holds the operand words steady. Finally it samples one unit's result per clock. The configuration guard is reached by raising the write strobe while a multiply is still in the pipeline, and the bench then shows that the old routing is still in force.

// File: rtl/pe_group_pkg.sv
package pe_group_pkg;
  localparam int NUM_FU  = 4;
  localparam int NUM_SRC = 2 * NUM_FU;
  localparam int SEL_W   = $clog2(NUM_SRC);
  localparam int OP_W    = 3;
  localparam int IDX_W   = $clog2(NUM_FU);
  localparam int XSEL_W  = NUM_FU * 2 * SEL_W;
  localparam int CFG_W   = XSEL_W + 1;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_MUL = 3'd5,
    OP_LD  = 3'd6,
    OP_ST  = 3'd7
  } pe_op_e;

  function automatic logic op_is_alu(input logic [OP_W-1:0] op);
    return op <= OP_XOR;
  endfunction

  function automatic logic op_is_mem(input logic [OP_W-1:0] op);
    return (op == OP_LD) || (op == OP_ST);
  endfunction
endpackage

// File: rtl/pe_xbar.sv
module pe_xbar
  import pe_group_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [XSEL_W-1:0]        sel,
  input  logic [NUM_FU*DATA_W-1:0] ext,
  input  logic [NUM_FU*DATA_W-1:0] fb,
  output logic [NUM_FU*DATA_W-1:0] opa,
  output logic [NUM_FU*DATA_W-1:0] opb
);
  logic [DATA_W-1:0] pool [NUM_SRC];

  generate
    for (genvar s = 0; s < NUM_FU; s++) begin : g_pool
      assign pool[s]          = ext[s*DATA_W +: DATA_W];
      assign pool[s + NUM_FU] = fb[s*DATA_W +: DATA_W];
    end
    for (genvar f = 0; f < NUM_FU; f++) begin : g_port
      assign opa[f*DATA_W +: DATA_W] = pool[sel[(2*f)*SEL_W +: SEL_W]];
      assign opb[f*DATA_W +: DATA_W] = pool[sel[(2*f+1)*SEL_W +: SEL_W]];
    end
  endgenerate
endmodule

// File: rtl/pe_skew.sv
module pe_skew
  import pe_group_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dp_mode,
  input  logic [NUM_FU-1:0]      in_valid,
  input  logic [NUM_FU*OP_W-1:0] in_op,
  output logic [NUM_FU-1:0]      iss_valid,
  output logic [NUM_FU*OP_W-1:0] iss_op,
  output logic                   pending
);
  logic [NUM_FU-1:0] dly_v;
  logic [OP_W-1:0]   dly_op [NUM_FU];

  assign dly_v[0]  = dp_mode & in_valid[0];
  assign dly_op[0] = in_op[OP_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_v[NUM_FU-1:1] <= '0;
    end else begin
      dly_v[NUM_FU-1:1] <= dly_v[NUM_FU-2:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int d = 1; d < NUM_FU; d++) begin
      dly_op[d] <= dly_op[d-1];
    end
  end

  assign pending = |dly_v[NUM_FU-1:1];

  generate
    for (genvar f = 0; f < NUM_FU; f++) begin : g_iss
      assign iss_valid[f] = dp_mode ? dly_v[f] : in_valid[f];
      assign iss_op[f*OP_W +: OP_W] = dp_mode ? dly_op[f] : in_op[f*OP_W +: OP_W];
    end
  endgenerate
endmodule

// File: rtl/pe_fu.sv
module pe_fu
  import pe_group_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              wb_valid,
  input  logic [DATA_W-1:0] wb_data,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              wb_clash
);
  logic              alu_go;
  logic [DATA_W-1:0] alu_y;

  always_comb begin
    unique case (iss_op)
      OP_ADD:  alu_y = opa + opb;
      OP_SUB:  alu_y = opa - opb;
      OP_AND:  alu_y = opa & opb;
      OP_OR:   alu_y = opa | opb;
      OP_XOR:  alu_y = opa ^ opb;
      default: alu_y = '0;
    endcase
  end

  assign alu_go   = iss_valid && op_is_alu(iss_op);
  assign wb_clash = alu_go && wb_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (wb_valid) begin
      res_valid <= 1'b1;
      res_data  <= wb_data;
    end else if (alu_go) begin
      res_valid <= 1'b1;
      res_data  <= alu_y;
    end else begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pe_shared.sv
module pe_shared
  import pe_group_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_FU-1:0]        iss_valid,
  input  logic [NUM_FU*OP_W-1:0]   iss_op,
  input  logic [NUM_FU*DATA_W-1:0] opa,
  input  logic [NUM_FU*DATA_W-1:0] opb,
  output logic [NUM_FU-1:0]        mul_want,
  output logic [NUM_FU-1:0]        mem_want,
  output logic [NUM_FU-1:0]        wb_valid,
  output logic [DATA_W-1:0]        wb_data,
  output logic                     mul_busy,
  output logic                     over_sub,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic [IDX_W-1:0]         mem_fu
);
  logic [IDX_W-1:0]  mul_sel, mem_sel;
  logic              st_v;
  logic [IDX_W-1:0]  st_fu;
  logic [DATA_W-1:0] st_a, st_b;

  always_comb begin
    mul_sel = '0;
    mem_sel = '0;
    for (int f = 0; f < NUM_FU; f++) begin
      mul_want[f] = iss_valid[f] && (iss_op[f*OP_W +: OP_W] == OP_MUL);
      mem_want[f] = iss_valid[f] && op_is_mem(iss_op[f*OP_W +: OP_W]);
    end
    for (int f = NUM_FU - 1; f >= 0; f--) begin
      if (mul_want[f]) mul_sel = IDX_W'(f);
      if (mem_want[f]) mem_sel = IDX_W'(f);
    end
  end

  assign over_sub = ((mul_want & (mul_want - 1'b1)) != '0) ||
                    ((mem_want & (mem_want - 1'b1)) != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_v <= 1'b0;
    end else begin
      st_v <= |mul_want;
    end
  end

  always_ff @(posedge clk) begin
    st_fu <= mul_sel;
    st_a  <= opa[mul_sel*DATA_W +: DATA_W];
    st_b  <= opb[mul_sel*DATA_W +: DATA_W];
  end

  assign wb_data  = st_a * st_b;
  assign mul_busy = st_v;

  generate
    for (genvar f = 0; f < NUM_FU; f++) begin : g_wb
      assign wb_valid[f] = st_v && (st_fu == IDX_W'(f));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
    end else begin
      mem_req <= |mem_want;
      mem_we  <= (|mem_want) && (iss_op[mem_sel*OP_W +: OP_W] == OP_ST);
    end
  end

  always_ff @(posedge clk) begin
    mem_addr  <= opa[mem_sel*DATA_W +: ADDR_W];
    mem_wdata <= opb[mem_sel*DATA_W +: DATA_W];
    mem_fu    <= mem_sel;
  end
endmodule

// File: rtl/pe_group.sv
module pe_group
  import pe_group_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [CFG_W-1:0]         cfg_data,
  input  logic [NUM_FU-1:0]        uop_valid,
  input  logic [NUM_FU*OP_W-1:0]   uop_op,
  input  logic [NUM_FU*DATA_W-1:0] src_data,
  output logic [NUM_FU-1:0]        res_valid,
  output logic [NUM_FU*DATA_W-1:0] res_data,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic [IDX_W-1:0]         mem_fu,
  output logic                     contention_err
);
  logic [CFG_W-1:0]         cfg_q;
  logic                     dp_mode;
  logic                     skew_pend;
  logic                     mul_busy;
  logic                     grp_idle;
  logic                     over_sub;
  logic [NUM_FU-1:0]        iss_valid;
  logic [NUM_FU*OP_W-1:0]   iss_op;
  logic [NUM_FU*DATA_W-1:0] opa, opb;
  logic [NUM_FU-1:0]        mul_want, mem_want, wb_valid, wb_clash, alu_go;
  logic [DATA_W-1:0]        wb_data;

  assign dp_mode  = cfg_q[CFG_W-1];
  assign grp_idle = ~(|uop_valid) && !skew_pend && !mul_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (cfg_we && grp_idle) begin
      cfg_q <= cfg_data;
    end
  end

  pe_skew u_skew (
    .clk       (clk),
    .rst       (rst),
    .dp_mode   (dp_mode),
    .in_valid  (uop_valid),
    .in_op     (uop_op),
    .iss_valid (iss_valid),
    .iss_op    (iss_op),
    .pending   (skew_pend)
  );

  pe_xbar #(.DATA_W(DATA_W)) u_xbar (
    .sel (cfg_q[XSEL_W-1:0]),
    .ext (src_data),
    .fb  (res_data),
    .opa (opa),
    .opb (opb)
  );

  pe_shared #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shared (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_op    (iss_op),
    .opa       (opa),
    .opb       (opb),
    .mul_want  (mul_want),
    .mem_want  (mem_want),
    .wb_valid  (wb_valid),
    .wb_data   (wb_data),
    .mul_busy  (mul_busy),
    .over_sub  (over_sub),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_fu    (mem_fu)
  );

  generate
    for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
      assign alu_go[f] = iss_valid[f] && op_is_alu(iss_op[f*OP_W +: OP_W]);
      pe_fu #(.DATA_W(DATA_W)) u_fu (
        .clk       (clk),
        .rst       (rst),
        .iss_valid (iss_valid[f]),
        .iss_op    (iss_op[f*OP_W +: OP_W]),
        .opa       (opa[f*DATA_W +: DATA_W]),
        .opb       (opb[f*DATA_W +: DATA_W]),
        .wb_valid  (wb_valid[f]),
        .wb_data   (wb_data),
        .res_valid (res_valid[f]),
        .res_data  (res_data[f*DATA_W +: DATA_W]),
        .wb_clash  (wb_clash[f])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      contention_err <= 1'b0;
    end else if (over_sub || (|wb_clash)) begin
      contention_err <= 1'b1;
    end
  end
endmodule

// File: rtl/pe_group_chk.sv
module pe_group_chk
  import pe_group_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [NUM_FU-1:0] res_valid,
  input logic              mem_req,
  input logic              contention_err,
  input logic [NUM_FU-1:0] mul_want,
  input logic [NUM_FU-1:0] mem_want,
  input logic [NUM_FU-1:0] alu_go,
  input logic              grp_idle,
  input logic [CFG_W-1:0]  cfg_q
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (res_valid == '0 && !mem_req && !contention_err));

  // R2
  a_r2_alu_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (|alu_go) |=> (|res_valid));

  // R4
  a_r4_mul_two_cycle: assert property (@(posedge clk) disable iff (rst)
    (|mul_want) |-> ##2 (|res_valid));

  // R5
  a_r5_req_from_issue: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> $past(|mem_want));

  // R6
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    contention_err |=> contention_err);

  // R7
  a_r7_cfg_held_busy: assert property (@(posedge clk) disable iff (rst)
    !grp_idle |=> $stable(cfg_q));
endmodule

bind pe_group pe_group_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .res_valid      (res_valid),
  .mem_req        (mem_req),
  .contention_err (contention_err),
  .mul_want       (mul_want),
  .mem_want       (mem_want),
  .alu_go         (alu_go),
  .grp_idle       (grp_idle),
  .cfg_q          (cfg_q)
);

// File: tb/sim_pe_group.sv
`timescale 1ns/1ps
module sim_pe_group;
  import pe_group_pkg::*;

  localparam int DW = 16;
  localparam int AW = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [CFG_W-1:0]  cfg_data = '0;
  logic [3:0]        uop_valid = '0;
  logic [11:0]       uop_op = '0;
  logic [4*DW-1:0]   src_data = '0;
  logic [3:0]        res_valid;
  logic [4*DW-1:0]   res_data;
  logic              mem_req, mem_we, contention_err;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_wdata;
  logic [1:0]        mem_fu;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pe_group #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .uop_valid(uop_valid), .uop_op(uop_op), .src_data(src_data),
    .res_valid(res_valid), .res_data(res_data), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_fu(mem_fu), .contention_err(contention_err)
  );

  // {ops[11:0], src {s3,s2,s1,s0}, expected {r3,r2,r1,r0}}
  localparam logic [139:0] VEC [4] = '{
    {12'h000, 16'h0004, 16'h0003, 16'h0002, 16'h0001,
              16'h0005, 16'h0007, 16'h0005, 16'h0003},
    {3'd4, 3'd3, 3'd2, 3'd1, 16'h0F0F, 16'h00F0, 16'h0003, 16'h0010,
              16'h0F1F, 16'h0FFF, 16'h0000, 16'h000D},
    {3'd1, 3'd1, 3'd1, 3'd1, 16'h0002, 16'h0005, 16'h0001, 16'h0000,
              16'h0002, 16'h0003, 16'hFFFC, 16'hFFFF},
    {12'h000, 16'h8000, 16'h8000, 16'h0001, 16'hFFFF,
              16'h7FFF, 16'h0000, 16'h8001, 16'h0000}
  };

  function automatic logic [CFG_W-1:0] mk_cfg(input logic dp,
      input logic [2:0] a0, b0, a1, b1, a2, b2, a3, b3);
    return {dp, b3, a3, b2, a2, b1, a1, b0, a0};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic write_cfg(input logic [CFG_W-1:0] c);
    uop_valid = '0;
    cfg_data  = c;
    cfg_we    = 1'b1;
    tick();
    cfg_we    = 1'b0;
  endtask

  task automatic set_src(input logic [15:0] s0, s1, s2, s3);
    src_data = {s3, s2, s1, s0};
  endtask

  function automatic logic [15:0] res(input int k);
    return res_data[k*DW +: DW];
  endfunction

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [CFG_W-1:0] base_cfg;
    base_cfg = mk_cfg(1'b0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3, 3'd0);
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 res_valid", 64'(res_valid), 64'h0);
    chk("R1 mem_req", 64'(mem_req), 64'h0);
    chk("R1 err", 64'(contention_err), 64'h0);
    // R1 default config: both selects of FU0 at source 0
    uop_valid = 4'b0001; uop_op = 12'h000; set_src(16'd7, 16'd1, 16'd2, 16'd3);
    tick();
    chk("R1 default routing", {res_valid, res(0)}, {4'b0001, 16'd14});

    write_cfg(base_cfg);
    // R2 vector table
    for (int i = 0; i < 4; i++) begin
      uop_valid = 4'hF;
      uop_op    = VEC[i][139:128];
      src_data  = VEC[i][127:64];
      tick();
      chk("R2 valid", 64'(res_valid), 64'hF);
      chk("R2 data", res_data, VEC[i][63:0]);
    end
    uop_valid = '0;
    tick();

    // R3 bypass: FU1 operand A from FU0 result register
    write_cfg(mk_cfg(1'b0, 3'd0, 3'd1, 3'd4, 3'd1, 3'd2, 3'd3, 3'd3, 3'd0));
    uop_valid = 4'b0001; uop_op = 12'h000; set_src(16'd10, 16'd20, 16'd0, 16'd0);
    tick();
    uop_valid = 4'b0010; set_src(16'd0, 16'd5, 16'd0, 16'd0);
    tick();
    chk("R3 bypass", {res_valid, res(1)}, {4'b0010, 16'd35});
    uop_valid = '0;
    tick();
    write_cfg(base_cfg);

    // R4 multiplier latency and back-to-back issue on FU2
    uop_valid = 4'b0100; uop_op = 12'(5) << 6; set_src(16'd0, 16'd0, 16'd300, 16'd7);
    tick();
    chk("R4 not yet", 64'(res_valid), 64'h0);
    set_src(16'd0, 16'd0, 16'h0123, 16'h0010);
    tick();
    chk("R4 first product", {res_valid, res(2)}, {4'b0100, 16'h0834});
    uop_valid = '0;
    tick();
    chk("R4 second product", {res_valid, res(2)}, {4'b0100, 16'h1230});

    // R5 memory requests
    uop_valid = 4'b0010; uop_op = 12'(7) << 3; set_src(16'd0, 16'h0045, 16'hBEEF, 16'd0);
    tick();
    chk("R5 store", {mem_req, mem_we, mem_fu, mem_addr, mem_wdata},
        {1'b1, 1'b1, 2'd1, 8'h45, 16'hBEEF});
    chk("R5 no result", 64'(res_valid), 64'h0);
    uop_valid = 4'b1000; uop_op = 12'(6) << 9; set_src(16'd0, 16'd0, 16'd0, 16'h0123);
    tick();
    chk("R5 load", {mem_req, mem_we, mem_fu, mem_addr}, {1'b1, 1'b0, 2'd3, 8'h23});
    uop_valid = '0;
    tick();
    chk("R5 idle", 64'(mem_req), 64'h0);

    // R6 contention
    chk("R6 clean", 64'(contention_err), 64'h0);
    uop_valid = 4'b0101; uop_op = 12'(5) | (12'(5) << 6); set_src(16'd3, 16'd5, 16'd4, 16'd6);
    tick();
    chk("R6 flag raised", 64'(contention_err), 64'h1);
    uop_valid = '0;
    tick();
    chk("R6 lowest wins mul", {res_valid, res(0)}, {4'b0001, 16'd15});
    uop_valid = 4'b1010; uop_op = (12'(6) << 3) | (12'(6) << 9);
    set_src(16'd0, 16'h0011, 16'd0, 16'h0033);
    tick();
    chk("R6 lowest wins mem", {mem_fu, mem_addr}, {2'd1, 8'h11});
    uop_valid = '0;
    repeat (3) tick();
    chk("R6 sticky", 64'(contention_err), 64'h1);

    // R1 reset clears the flag
    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
    chk("R1 err cleared", 64'(contention_err), 64'h0);

    // R7 configuration write ignored while busy
    write_cfg(base_cfg);
    cfg_data = mk_cfg(1'b0, 3'd2, 3'd3, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3, 3'd0);
    cfg_we = 1'b1;
    uop_valid = 4'b0001; uop_op = 12'(5); set_src(16'd2, 16'd2, 16'd0, 16'd0);
    tick();
    uop_valid = '0;
    tick();
    cfg_we = 1'b0;
    tick();
    uop_valid = 4'b0001; uop_op = 12'h000; set_src(16'd1, 16'd2, 16'd100, 16'd200);
    tick();
    chk("R7 busy write ignored", {res_valid, res(0)}, {4'b0001, 16'd3});
    write_cfg(mk_cfg(1'b0, 3'd2, 3'd3, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3, 3'd0));
    uop_valid = 4'b0001;
    tick();
    chk("R7 idle write taken", {res_valid, res(0)}, {4'b0001, 16'd300});
    uop_valid = '0;
    tick();

    // R8 data-parallel skew
    write_cfg(mk_cfg(1'b1, 3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3, 3'd0));
    uop_valid = 4'hF; uop_op = 12'(5); set_src(16'd2, 16'd3, 16'd4, 16'd5);
    tick();
    chk("R8 lanes 1-3 inputs ignored", 64'(res_valid), 64'h0);
    uop_valid = '0;
    tick();
    chk("R8 unit0", {res_valid, res(0)}, {4'b0001, 16'd6});
    tick();
    chk("R8 unit1", {res_valid, res(1)}, {4'b0010, 16'd12});
    tick();
    chk("R8 unit2", {res_valid, res(2)}, {4'b0100, 16'd20});
    tick();
    chk("R8 unit3", {res_valid, res(3)}, {4'b1000, 16'd10});
    chk("R8 no contention", 64'(contention_err), 64'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule